// File: doc/BRIEF.md
# Quasi-Cyclic Partial Syndrome Accumulator

This block is the first stage of a quasi-cyclic LDPC encoder with a dual-diagonal parity part. It forms the partial syndrome of every row of the base matrix, which is the product of the information part of the parity-check matrix with the message over GF(2). The message arrives one z-bit sub-block per accepted beat, and each beat is one column of the information part. The block starts work on the first beat of a frame and does not first buffer the whole message. For each column, a small table holds up to six entries, one per nonzero circulant in that column. Six rotators run in parallel. Each one rotates the sub-block by its entry's scaled shift and XORs the result into the row register that the entry names. A later parity prediction and correction stage reads the row registers once the done flag rises.

A single base table serves every lifting size. Its shift values are rescaled for the selected size, using a proportional rule for the normal table and a modulo rule for the alternate table. The controller is a three-state machine. `S_IDLE` is the state after reset. `S_RUN` accepts sub-blocks. `S_DONE` holds the results. The transitions are: launch (`S_IDLE` to `S_RUN` on start), finish (`S_RUN` to `S_DONE` on the last column), restart (`S_RUN` to `S_RUN` on start) and relaunch (`S_DONE` to `S_RUN` on start).

Top module: `qcs_syndrome_unit`

## Requirements
- R1: After reset, `done` is 0 and every bit of `lambda_flat` is 0.
- R2: A cycle with `start` high clears all row registers and latches `rate_sel` and `zsel` for the frame. In the next cycle `done` is 0 and `lambda_flat` is all zeros.
- R3: The lifting size is z = 24 + 4·`zsel`, which gives code lengths 576 to 2304. A `zsel` value above 18 is treated as 18, so z = 96.
- R4: There are 12 base columns c and 12 rows. Column c holds 2 + (c mod 5) nonzero entries, indexed k = 0 upward. Entry k sits in row (c + 2k) mod 12. Its base value is p = (37c + 53k + 11) mod 96 for `rate_sel`=0 and p = (29c + 71k + 5) mod 96 for `rate_sel`=1. Every other position is a zero sub-block.
- R5: The applied shift is s = floor(p·z/96) for `rate_sel`=0 and s = p mod z for `rate_sel`=1.
- R6: An entry with shift s adds the vector y to its row, where y[i] = x[(i+s) mod z] for i < z and x is the sub-block. Input bits at positions z and above are ignored, and row bits at positions z and above stay 0.
- R7: At `done`, row r occupies `lambda_flat[r*96 +: 96]` and equals the XOR of all contributions that R4 to R6 assign to row r.
- R8: In `S_RUN` only, a cycle with `blk_valid` high and `start` low accepts a sub-block. The n-th accepted sub-block of a frame is column n−1, and idle cycles between sub-blocks are allowed.
- R9: `done` rises in the cycle after the 12th accepted sub-block and stays high until the next `start`. Sub-blocks offered in `S_IDLE` or `S_DONE` leave `lambda_flat` unchanged.
- R10: A `start` in `S_RUN` abandons the frame and begins a new one, and a sub-block offered in the same cycle as `start` is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a frame: clear rows, latch the selects |
| rate_sel | input | 1 | 0 = normal table with proportional scaling, 1 = alternate table with modulo scaling |
| zsel | input | 5 | Lifting size index, z = 24 + 4·zsel (clamped at 18) |
| blk_valid | input | 1 | Sub-block present on `blk_data` |
| blk_data | input | 96 | Information sub-block, bit i is the i-th bit of the column |
| done | output | 1 | All 12 columns have been accumulated |
| lambda_flat | output | 1152 | Twelve 96-bit row syndromes, row r at bits r*96 upward |

## Verification
The hardest case to reach from the ports is a rotation whose wrap point moves with z. Out-of-range bits must be dropped on the input side and must stay zero on the output side, and both matter only when z is below the full width. The frame tasks therefore sweep the smallest, a middle and the largest lifting size under both scaling rules. They drive sub-blocks whose bits above z are forced to ones, and they use single-bit columns that expose the rotation direction. Restart and idle-state traffic come from a start pulse issued mid-frame, with a sub-block offered in the same cycle, and from sub-blocks pushed before launch and after finish.

// File: rtl/qcs_pkg.sv
package qcs_pkg;

    parameter int MB    = 12;   // base-matrix rows
    parameter int KB    = 12;   // information columns
    parameter int NSH   = 6;    // rotators = max column weight
    parameter int ZMAX  = 96;   // largest lifting size, also scaling reference
    parameter int ZMIN  = 24;
    parameter int ZSTEP = 4;
    parameter int NZ    = 19;   // number of supported lifting sizes

    localparam int ZW   = $clog2(ZMAX + 1);
    localparam int PW   = $clog2(ZMAX);
    localparam int RW   = $clog2(MB);
    localparam int CW   = $clog2(KB + 1);
    localparam int SELW = $clog2(NZ);

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_DONE = 2'd2
    } fsm_t;

    typedef struct packed {
        logic          vld;
        logic [RW-1:0] row;
        logic [PW-1:0] p;
    } slot_t;

    localparam int ENTW = $bits(slot_t);

    // Base table, one entry per (column, slot), slots filled from 0 upward.
    function automatic logic [KB*NSH*ENTW-1:0] build_rom(input int sel);
        logic [KB*NSH*ENTW-1:0] img;
        slot_t                  e;
        int                     wgt;
        img = '0;
        for (int c = 0; c < KB; c++) begin
            wgt = 2 + (c % 5);
            if (wgt > NSH) wgt = NSH;
            for (int k = 0; k < NSH; k++) begin
                if (k < wgt) begin
                    e.vld = 1'b1;
                    e.row = RW'((c + 2 * k) % MB);
                    if (sel == 0) e.p = PW'((37 * c + 53 * k + 11) % ZMAX);
                    else          e.p = PW'((29 * c + 71 * k + 5) % ZMAX);
                    img[(c * NSH + k) * ENTW +: ENTW] = e;
                end
            end
        end
        return img;
    endfunction

endpackage

// File: rtl/qcs_shift_rom.sv
module qcs_shift_rom
    import qcs_pkg::*;
(
    input  logic [CW-1:0]            col,
    input  logic                     sel,
    output slot_t [NSH-1:0]          slots
);

    localparam logic [KB*NSH*ENTW-1:0] TBL_NORM = build_rom(0);
    localparam logic [KB*NSH*ENTW-1:0] TBL_ALT  = build_rom(1);

    logic in_range;
    assign in_range = (int'(col) < KB);

    for (genvar k = 0; k < NSH; k++) begin : g_slot
        slot_t norm_e, alt_e;
        always_comb begin
            norm_e = '0;
            alt_e  = '0;
            if (in_range) begin
                norm_e = TBL_NORM[(int'(col) * NSH + k) * ENTW +: ENTW];
                alt_e  = TBL_ALT [(int'(col) * NSH + k) * ENTW +: ENTW];
            end
            slots[k] = sel ? alt_e : norm_e;
        end
    end

endmodule

// File: rtl/qcs_shift_scale.sv
module qcs_shift_scale
    import qcs_pkg::*;
(
    input  logic [PW-1:0] p,
    input  logic [ZW-1:0] z,
    input  logic          modulo_rule,
    output logic [ZW-1:0] s
);

    logic [PW+ZW-1:0] prod;
    logic [ZW-1:0]    s_prop;
    logic [ZW-1:0]    s_mod;

    always_comb begin
        prod   = (PW+ZW)'(p) * (PW+ZW)'(z);
        s_prop = ZW'(prod / (PW+ZW)'(ZMAX));
        s_mod  = ZW'(ZW'(p) % z);
        s      = modulo_rule ? s_mod : s_prop;
    end

endmodule

// File: rtl/qcs_rotator.sv
module qcs_rotator
    import qcs_pkg::*;
(
    input  logic [ZMAX-1:0] x,     // bits at and above z are zero
    input  logic [ZW-1:0]   z,
    input  logic [ZW-1:0]   s,     // s < z
    output logic [ZMAX-1:0] y
);

    logic [2*ZMAX-1:0] dbl;
    logic [ZMAX-1:0]   keep;

    always_comb begin
        // second copy of x placed right above bit z-1 closes the ring
        dbl  = {{ZMAX{1'b0}}, x} | ({{ZMAX{1'b0}}, x} << z);
        keep = {ZMAX{1'b1}} >> (ZW'(ZMAX) - z);
        y    = ZMAX'(dbl >> s) & keep;
    end

endmodule

// File: rtl/qcs_lambda_acc.sv
module qcs_lambda_acc
    import qcs_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       en,
    input  logic [NSH-1:0]             vld,
    input  logic [NSH-1:0][RW-1:0]     row,
    input  logic [NSH-1:0][ZMAX-1:0]   rot,
    output logic [MB-1:0][ZMAX-1:0]    lam
);

    logic [MB-1:0][ZMAX-1:0] inc;

    for (genvar r = 0; r < MB; r++) begin : g_row
        always_comb begin
            inc[r] = '0;
            for (int k = 0; k < NSH; k++) begin
                if (vld[k] && (row[k] == RW'(r)))
                    inc[r] = inc[r] ^ rot[k];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                lam[r] <= '0;
            else if (clr)
                lam[r] <= '0;
            else if (en)
                lam[r] <= lam[r] ^ inc[r];
        end
    end

    // R2: a clear leaves every row at zero
    a_r2_clear_rows: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (lam == '0));

    // R9: without clear or accept the rows hold
    a_r9_rows_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> $stable(lam));

endmodule

// File: rtl/qcs_syndrome_unit.sv
module qcs_syndrome_unit
    import qcs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 rate_sel,
    input  logic [SELW-1:0]      zsel,
    input  logic                 blk_valid,
    input  logic [ZMAX-1:0]      blk_data,
    output logic                 done,
    output logic [MB*ZMAX-1:0]   lambda_flat
);

    fsm_t                      state, state_nx;
    logic [CW-1:0]             col_cnt;
    logic [ZW-1:0]             z_q;
    logic                      rate_q;
    logic                      accept;
    logic                      last_col;
    logic                      clr_rows;
    logic [SELW-1:0]           zsel_c;
    logic [ZW-1:0]             z_new;
    logic [ZMAX-1:0]           in_mask;
    logic [ZMAX-1:0]           x_m;
    slot_t [NSH-1:0]           slots;
    logic [NSH-1:0]            s_vld;
    logic [NSH-1:0][RW-1:0]    s_row;
    logic [NSH-1:0][ZW-1:0]    s_amt;
    logic [NSH-1:0][ZMAX-1:0]  s_rot;
    logic [MB-1:0][ZMAX-1:0]   lam;

    // lifting size from the select, clamped to the largest size
    always_comb begin
        zsel_c = (int'(zsel) > NZ - 1) ? SELW'(NZ - 1) : zsel;
        z_new  = ZW'(ZMIN) + ZW'(ZSTEP) * ZW'(zsel_c);
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (start) state_nx = S_RUN;             // launch
            S_RUN: begin
                if (start)         state_nx = S_RUN;          // restart
                else if (last_col) state_nx = S_DONE;         // finish
            end
            S_DONE: if (start) state_nx = S_RUN;              // relaunch
            default:           state_nx = S_IDLE;
        endcase
    end

    // ---------------- outputs / strobes ----------------
    always_comb begin
        accept   = 1'b0;
        clr_rows = start;
        done     = 1'b0;
        unique case (state)
            S_IDLE: ;
            S_RUN:  accept = blk_valid && !start;
            S_DONE: done   = 1'b1;
            default: ;
        endcase
        last_col = accept && (int'(col_cnt) == KB - 1);
    end

    // ---------------- frame context ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_cnt <= '0;
            z_q     <= ZW'(ZMIN);
            rate_q  <= 1'b0;
        end else if (start) begin
            col_cnt <= '0;
            z_q     <= z_new;
            rate_q  <= rate_sel;
        end else if (accept) begin
            col_cnt <= last_col ? '0 : col_cnt + 1'b1;
        end
    end

    // drop input bits outside the current lifting size
    always_comb begin
        in_mask = {ZMAX{1'b1}} >> (ZW'(ZMAX) - z_q);
        x_m     = blk_data & in_mask;
    end

    qcs_shift_rom u_rom (
        .col   (col_cnt),
        .sel   (rate_q),
        .slots (slots)
    );

    for (genvar k = 0; k < NSH; k++) begin : g_lane
        assign s_vld[k] = slots[k].vld;
        assign s_row[k] = slots[k].row;

        qcs_shift_scale u_scale (
            .p           (slots[k].p),
            .z           (z_q),
            .modulo_rule (rate_q),
            .s           (s_amt[k])
        );

        qcs_rotator u_rot (
            .x (x_m),
            .z (z_q),
            .s (s_amt[k]),
            .y (s_rot[k])
        );

        // R5: a scaled shift always falls inside the circulant
        a_r5_shift_in_range: assert property (@(posedge clk) disable iff (!rst_n)
            (state == S_RUN) |-> (s_amt[k] < z_q));
    end

    qcs_lambda_acc u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_rows),
        .en    (accept),
        .vld   (s_vld),
        .row   (s_row),
        .rot   (s_rot),
        .lam   (lam)
    );

    assign lambda_flat = lam;

    // R9: the twelfth accepted column raises done on the next cycle
    a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN && blk_valid && !start && int'(col_cnt) == KB - 1) |=> done);

    // R9: done stays up until a start
    a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R3: latched lifting size lies within the supported range
    a_r3_size_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN) |-> (z_q >= ZW'(ZMIN) && z_q <= ZW'(ZMAX)));

    // R8: column counter never leaves the information part
    a_r8_col_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(col_cnt) < KB));

    // R10: start in the run state yields a fresh frame at column zero
    a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state == S_RUN) |=> (state == S_RUN && col_cnt == '0));

endmodule

// File: tb/qcs_syndrome_unit_test.sv
module qcs_syndrome_unit_test;
    import qcs_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 start;
    logic                 rate_sel;
    logic [SELW-1:0]      zsel;
    logic                 blk_valid;
    logic [ZMAX-1:0]      blk_data;
    logic                 done;
    logic [MB*ZMAX-1:0]   lambda_flat;

    int n_vec = 0;
    int n_bad = 0;

    logic [ZMAX-1:0] msg   [KB];
    logic [ZMAX-1:0] exp_l [MB];
    int unsigned     rng = 32'h1234_5678;

    always #5 clk = ~clk;

    qcs_syndrome_unit uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .rate_sel    (rate_sel),
        .zsel        (zsel),
        .blk_valid   (blk_valid),
        .blk_data    (blk_data),
        .done        (done),
        .lambda_flat (lambda_flat)
    );

    function automatic logic [ZMAX-1:0] row_of(int r);
        return lambda_flat[r*ZMAX +: ZMAX];
    endfunction

    function automatic int unsigned next_rand();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng;
    endfunction

    task automatic check_bit(string tag, logic act, logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic check_vec(string tag, logic [ZMAX-1:0] act, logic [ZMAX-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // pattern: 0 zeros, 1 ones, 2 one bit per column, 3 random
    task automatic fill_msg(int pat, int z);
        for (int c = 0; c < KB; c++) begin
            logic [ZMAX-1:0] v;
            v = '0;
            case (pat)
                1: v = '1;
                2: v[(3 * c + 1) % z] = 1'b1;
                3: v = {next_rand(), next_rand(), next_rand()};
                default: v = '0;
            endcase
            msg[c] = v;
        end
    endtask

    // GF(2) product of the information part of H with the message
    task automatic build_ref(int rate, int z);
        for (int r = 0; r < MB; r++) exp_l[r] = '0;
        for (int c = 0; c < KB; c++) begin
            for (int k = 0; k < 2 + (c % 5); k++) begin
                int r, p, s;
                r = (c + 2 * k) % MB;
                p = (rate == 0) ? (37 * c + 53 * k + 11) % 96 : (29 * c + 71 * k + 5) % 96;
                s = (rate == 0) ? (p * z) / 96 : p % z;
                for (int i = 0; i < z; i++)
                    for (int j = 0; j < z; j++)
                        if (j == (i + s) % z)
                            exp_l[r][i] = exp_l[r][i] ^ msg[c][j];
            end
        end
    endtask

    task automatic pulse_start(int rate, int zs);
        start    = 1'b1;
        rate_sel = rate[0];
        zsel     = SELW'(zs);
        @(negedge clk);
        start    = 1'b0;
    endtask

    // sends a whole frame and checks done timing and every row
    task automatic run_frame(string name, int rate, int zs, int pat, bit gaps, bit junk);
        int zc, z;
        zc = (zs > NZ - 1) ? NZ - 1 : zs;
        z  = ZMIN + ZSTEP * zc;
        fill_msg(pat, z);
        build_ref(rate, z);
        pulse_start(rate, zs);
        for (int c = 0; c < KB; c++) begin
            if (gaps && (c % 3 == 1)) begin
                blk_valid = 1'b0;
                blk_data  = '1;
                @(negedge clk);
            end
            if (c == KB - 1)
                check_bit({name, " R9 done low before last column"}, done, 1'b0);
            blk_valid = 1'b1;
            blk_data  = msg[c];
            if (junk) blk_data = blk_data | ({ZMAX{1'b1}} << z);
            @(negedge clk);
        end
        blk_valid = 1'b0;
        blk_data  = '0;
        check_bit({name, " R9 done after last column"}, done, 1'b1);
        for (int r = 0; r < MB; r++)
            check_vec($sformatf("%s R4 R5 R6 R7 row %0d", name, r), row_of(r), exp_l[r]);
    endtask

    task automatic test_reset();
        check_bit("R1 done at reset", done, 1'b0);
        n_vec++;
        if (lambda_flat !== '0) begin
            n_bad++;
            $display("FAIL R1 lambda at reset: actual nonzero expected 0");
        end
    endtask

    task automatic test_idle_ignored();
        blk_valid = 1'b1;
        blk_data  = '1;
        repeat (3) @(negedge clk);
        blk_valid = 1'b0;
        n_vec++;
        if (lambda_flat !== '0) begin
            n_bad++;
            $display("FAIL R9 idle sub-blocks changed rows: actual nonzero expected 0");
        end
        check_bit("R9 done stays low in idle", done, 1'b0);
    endtask

    task automatic test_done_ignored();
        logic [MB*ZMAX-1:0] snap;
        snap      = lambda_flat;
        blk_valid = 1'b1;
        blk_data  = {next_rand(), next_rand(), next_rand()};
        repeat (3) @(negedge clk);
        blk_valid = 1'b0;
        n_vec++;
        if (lambda_flat !== snap) begin
            n_bad++;
            $display("FAIL R9 sub-blocks after done changed rows: actual %h expected %h",
                     lambda_flat[ZMAX-1:0], snap[ZMAX-1:0]);
        end
        check_bit("R9 done held", done, 1'b1);
    endtask

    task automatic test_start_clears();
        pulse_start(1, 5);
        check_bit("R2 done cleared by start", done, 1'b0);
        n_vec++;
        if (lambda_flat !== '0) begin
            n_bad++;
            $display("FAIL R2 rows after start: actual nonzero expected 0");
        end
    endtask

    task automatic test_restart();
        pulse_start(0, 10);
        for (int c = 0; c < 5; c++) begin
            blk_valid = 1'b1;
            blk_data  = {next_rand(), next_rand(), next_rand()};
            @(negedge clk);
        end
        // new frame, with a sub-block offered alongside start (R10: not accepted)
        blk_valid = 1'b1;
        blk_data  = '1;
        run_frame("R10 restart", 1, 12, 3, 1'b0, 1'b0);
    endtask

    initial begin
        rst_n     = 1'b0;
        start     = 1'b0;
        rate_sel  = 1'b0;
        zsel      = '0;
        blk_valid = 1'b0;
        blk_data  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        test_reset();
        test_idle_ignored();
        run_frame("R8 R3 min z single-bit", 0, 0, 2, 1'b0, 1'b0);
        test_done_ignored();
        run_frame("R8 gaps mid z random", 0, 9, 3, 1'b1, 1'b0);
        run_frame("R5 modulo rule max z", 1, 18, 3, 1'b0, 1'b0);
        run_frame("R6 junk upper bits z 24", 1, 0, 3, 1'b1, 1'b1);
        run_frame("R6 all ones z 60", 0, 9, 1, 1'b0, 1'b1);
        run_frame("R3 clamp zsel 25", 0, 25, 3, 1'b0, 1'b0);
        run_frame("R7 all zeros", 1, 7, 0, 1'b0, 1'b0);
        run_frame("R6 single-bit modulo", 1, 3, 2, 1'b1, 1'b0);
        test_start_clears();
        test_restart();

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule